// File: doc/BRIEF.md
# Type B Contactless Frame Encoder

This block turns a sequence of bytes into the bit-level sample stream of one Type B contactless frame. After a start pulse it sends a start-of-frame marker. It then sends each byte as a ten-bit character, and it closes the frame with an end-of-frame marker. The stream goes one sample per cycle over a valid/ready handshake to a modulator or to a packer placed after it. Bytes come in through their own valid/ready handshake, and a last flag marks the final byte of the frame.

A mode input is sampled together with the start pulse and selects one of two forms.

- **Card-side (tag) form:** every elementary time unit (etu) is stretched to four identical samples. A long run of ones is sent before the start-of-frame marker so that the far end can lock onto the subcarrier phase.
- **Reader-side form:** each etu is a single sample. The end-of-frame marker is shorter, and a fixed run of ones is added at the end so that a downstream byte packer can fill its last word.

CRC bytes are supplied by the user inside the byte stream.

Top module: `typeb_frame_serializer`

## Requirements
- R1: After reset, `smp_valid_o`, `in_ready_o` and `done_o` are all low, and no sample is offered until a start pulse arrives.
- R2: Each byte is sent as one start etu of 0, then its eight data bits with bit 0 first, then one stop etu of 1.
- R3: Every frame begins its marker with ten etus of 0 followed by two etus of 1, and the first character follows directly.
- R4: In tag form (`tag_mode_i`=1 at start), the frame ends with ten etus of 0 followed by two etus of 1.
- R5: In reader form (`tag_mode_i`=0 at start), the frame ends with ten etus of 0 followed by one etu of 1.
- R6: In reader form, exactly eight samples of 1 follow the end marker before the frame completes.
- R7: In tag form, each etu appears as four consecutive identical samples. In reader form, each etu appears as one sample.
- R8: In tag form, 80 samples of 1 (20 etus) come before the start-of-frame marker.
- R9: Characters are back to back: the stop etu of one byte is followed directly by the start etu of the next, with no idle etus between them.
- R10: While the next byte is due and `in_valid_i` is low, `in_ready_o` stays high and `smp_valid_o` stays low. No filler samples are produced.
- R11: A start pulse that arrives while a frame is in progress is ignored. The frame and its mode continue unchanged, and no second frame is produced.
- R12: `done_o` is high for exactly one cycle, namely the cycle after the last sample of the frame is accepted.
- R13: While `smp_valid_o` is high and `smp_ready_i` is low, the offered sample value and `smp_valid_o` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a frame when idle |
| tag_mode_i | input | 1 | Form select sampled at start: 1 = tag form, 0 = reader form |
| in_data_i | input | DATA_W | Byte to send |
| in_valid_i | input | 1 | `in_data_i` holds a byte |
| in_last_i | input | 1 | The offered byte is the last one of the frame |
| in_ready_o | output | 1 | Encoder takes the offered byte this cycle |
| smp_o | output | 1 | Current output sample level |
| smp_valid_o | output | 1 | `smp_o` is being offered |
| smp_ready_i | input | 1 | Downstream accepts the sample this cycle |
| done_o | output | 1 | One-cycle pulse after the last sample is accepted |

## Verification
The properties assume the following about the inputs:
- A byte is always offered with its last flag, and each frame carries at least one byte.
- The producer keeps `in_data_i` and `in_last_i` steady while `in_valid_i` waits on `in_ready_o`.

The stimulus meets these assumptions by design. Its byte task raises valid only together with a settled byte and last flag, and it drops valid right after the accepting edge. Downstream backpressure is random. A start pulse with the opposite mode is injected only in the middle of a frame, while the encoder is busy.

// File: rtl/typeb_enc_pkg.sv
package typeb_enc_pkg;

   // Frame phases in transmission order; PH_LOAD waits for a byte.
   typedef enum logic [3:0] {
      PH_IDLE,
      PH_PRE,
      PH_SOF_LO,
      PH_SOF_HI,
      PH_LOAD,
      PH_CHAR,
      PH_EOF_LO,
      PH_EOF_HI,
      PH_PAD
   } phase_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/typeb_etu_timer.sv
module typeb_etu_timer #(
   parameter int OVERSAMPLE = 4,
   parameter int CNT_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             os_en,
   input  logic [CNT_W-1:0] phase_len,
   output logic [CNT_W-1:0] etu_idx,
   output logic             phase_end
);

   logic             etu_done;
   logic [CNT_W-1:0] idx_q;

   generate
      if (OVERSAMPLE > 1) begin : g_os
         localparam int SUB_W = $clog2(OVERSAMPLE);
         logic [SUB_W-1:0] sub_q;
         logic             sub_last;

         assign sub_last = (sub_q == SUB_W'(OVERSAMPLE - 1));
         assign etu_done = fire && (!os_en || sub_last);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sub_q <= '0;
            end else if (fire && os_en) begin
               sub_q <= sub_last ? '0 : sub_q + 1'b1;
            end
         end
      end else begin : g_single
         assign etu_done = fire;
      end
   endgenerate

   assign phase_end = etu_done && (idx_q == phase_len - 1'b1);
   assign etu_idx   = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (phase_end) begin
         idx_q <= '0;
      end else if (etu_done) begin
         idx_q <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/typeb_char_reg.sv
module typeb_char_reg #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic [CNT_W-1:0]  bit_idx,
   output logic              bit_o
);

   localparam int CHAR_W = DATA_W + 2;

   logic [CHAR_W-1:0] char_q;

   // Index 0 is the start etu, the last index is the stop etu.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         char_q <= '1;
      end else if (load) begin
         char_q <= {1'b1, data, 1'b0};
      end
   end

   always_comb begin
      bit_o = 1'b1;
      for (int i = 0; i < CHAR_W; i++) begin
         if (bit_idx == CNT_W'(i)) bit_o = char_q[i];
      end
   end

endmodule

// File: rtl/typeb_phase_seq.sv
module typeb_phase_seq
   import typeb_enc_pkg::*;
#(
   parameter int PAD_SAMPLES = 8
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   tag_mode,
   input  logic   phase_end,
   input  logic   byte_take,
   input  logic   byte_last,
   output phase_e phase,
   output logic   tag_q,
   output logic   done
);

   phase_e phase_q;
   logic   last_q;
   logic   done_q;
   logic   frame_final;

   localparam bit HAS_PAD = (PAD_SAMPLES > 0);

   assign frame_final = phase_end &&
      ((phase_q == PH_EOF_HI && (tag_q || !HAS_PAD)) || phase_q == PH_PAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         tag_q   <= 1'b0;
         last_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= frame_final;
         unique case (phase_q)
            PH_IDLE: if (start) begin
               tag_q   <= tag_mode;
               phase_q <= tag_mode ? PH_PRE : PH_SOF_LO;
            end
            PH_PRE:    if (phase_end) phase_q <= PH_SOF_LO;
            PH_SOF_LO: if (phase_end) phase_q <= PH_SOF_HI;
            PH_SOF_HI: if (phase_end) phase_q <= PH_LOAD;
            PH_LOAD: if (byte_take) begin
               last_q  <= byte_last;
               phase_q <= PH_CHAR;
            end
            PH_CHAR:   if (phase_end) phase_q <= last_q ? PH_EOF_LO : PH_LOAD;
            PH_EOF_LO: if (phase_end) phase_q <= PH_EOF_HI;
            PH_EOF_HI: if (phase_end) phase_q <= (tag_q || !HAS_PAD) ? PH_IDLE : PH_PAD;
            PH_PAD:    if (phase_end) phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign done  = done_q;

endmodule

// File: rtl/typeb_frame_serializer.sv
module typeb_frame_serializer
   import typeb_enc_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int OVERSAMPLE   = 4,
   parameter int PRE_ETU      = 20,
   parameter int SOF_LO_ETU   = 10,
   parameter int SOF_HI_ETU   = 2,
   parameter int EOF_LO_ETU   = 10,
   parameter int TAG_EOF_HI   = 2,
   parameter int RDR_EOF_HI   = 1,
   parameter int RDR_PAD      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              tag_mode_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              in_valid_i,
   input  logic              in_last_i,
   output logic              in_ready_o,
   output logic              smp_o,
   output logic              smp_valid_o,
   input  logic              smp_ready_i,
   output logic              done_o
);

   localparam int CHAR_ETU = DATA_W + 2;
   localparam int MAX_LEN  = max_of(max_of(max_of(PRE_ETU, SOF_LO_ETU), max_of(SOF_HI_ETU, EOF_LO_ETU)),
                                    max_of(max_of(TAG_EOF_HI, RDR_EOF_HI), max_of(RDR_PAD, CHAR_ETU)));
   localparam int CNT_W    = $clog2(MAX_LEN + 1);

   generate
      if (OVERSAMPLE < 1) begin : g_bad_os
         $error("OVERSAMPLE must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be at least 1");
      end
      if (PRE_ETU < 1 || SOF_LO_ETU < 1 || SOF_HI_ETU < 1 || EOF_LO_ETU < 1) begin : g_bad_len
         $error("marker lengths must be at least one etu");
      end
      if (TAG_EOF_HI < 1 || RDR_EOF_HI < 1 || RDR_PAD < 0) begin : g_bad_tail
         $error("end marker high part must be at least one etu");
      end
   endgenerate

   phase_e           phase;
   logic             tag_q;
   logic             fire;
   logic             phase_end;
   logic [CNT_W-1:0] etu_idx;
   logic [CNT_W-1:0] phase_len;
   logic             char_bit;
   logic             byte_take;

   assign in_ready_o  = (phase == PH_LOAD);
   assign smp_valid_o = (phase != PH_IDLE) && (phase != PH_LOAD);
   assign fire        = smp_valid_o && smp_ready_i;
   assign byte_take   = in_ready_o && in_valid_i;

   always_comb begin
      unique case (phase)
         PH_PRE:    phase_len = CNT_W'(PRE_ETU);
         PH_SOF_LO: phase_len = CNT_W'(SOF_LO_ETU);
         PH_SOF_HI: phase_len = CNT_W'(SOF_HI_ETU);
         PH_CHAR:   phase_len = CNT_W'(CHAR_ETU);
         PH_EOF_LO: phase_len = CNT_W'(EOF_LO_ETU);
         PH_EOF_HI: phase_len = tag_q ? CNT_W'(TAG_EOF_HI) : CNT_W'(RDR_EOF_HI);
         PH_PAD:    phase_len = CNT_W'(RDR_PAD);
         default:   phase_len = CNT_W'(1);
      endcase
   end

   always_comb begin
      unique case (phase)
         PH_SOF_LO, PH_EOF_LO: smp_o = 1'b0;
         PH_CHAR:              smp_o = char_bit;
         default:              smp_o = 1'b1;
      endcase
   end

   typeb_phase_seq #(
      .PAD_SAMPLES (RDR_PAD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .tag_mode  (tag_mode_i),
      .phase_end (phase_end),
      .byte_take (byte_take),
      .byte_last (in_last_i),
      .phase     (phase),
      .tag_q     (tag_q),
      .done      (done_o)
   );

   typeb_etu_timer #(
      .OVERSAMPLE (OVERSAMPLE),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .os_en     (tag_q),
      .phase_len (phase_len),
      .etu_idx   (etu_idx),
      .phase_end (phase_end)
   );

   typeb_char_reg #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_char (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (byte_take),
      .data    (in_data_i),
      .bit_idx (etu_idx),
      .bit_o   (char_bit)
   );

endmodule

// File: rtl/typeb_frame_serializer_chk.sv
module typeb_frame_serializer_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic in_valid_i,
   input logic in_ready_o,
   input logic smp_o,
   input logic smp_valid_o,
   input logic smp_ready_i,
   input logic done_o
);

   p_hold_under_backpressure_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_o)));

   p_no_sample_while_waiting_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> !smp_valid_o);

   p_keep_waiting_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready_o && !in_valid_i) |=> in_ready_o);

   p_done_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(smp_valid_o && smp_ready_i));

   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_idle_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (!smp_valid_o && !in_ready_o));

   p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready_o && start_i && !in_valid_i) |=> in_ready_o);

endmodule

bind typeb_frame_serializer typeb_frame_serializer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .in_valid_i  (in_valid_i),
   .in_ready_o  (in_ready_o),
   .smp_o       (smp_o),
   .smp_valid_o (smp_valid_o),
   .smp_ready_i (smp_ready_i),
   .done_o      (done_o)
);

// File: tb/typeb_frame_serializer_test.sv
module typeb_frame_serializer_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       tag_mode_i = 1'b0;
   logic [7:0] in_data_i = '0;
   logic       in_valid_i = 1'b0;
   logic       in_last_i = 1'b0;
   logic       in_ready_o;
   logic       smp_o;
   logic       smp_valid_o;
   logic       smp_ready_i = 1'b1;
   logic       done_o;

   int   n_checks = 0;
   int   n_fail = 0;
   int   done_cnt = 0;
   bit   bp_en = 1'b0;
   bit   fin = 1'b0;

   logic  q_bit[$];
   string q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   typeb_frame_serializer uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .tag_mode_i  (tag_mode_i),
      .in_data_i   (in_data_i),
      .in_valid_i  (in_valid_i),
      .in_last_i   (in_last_i),
      .in_ready_o  (in_ready_o),
      .smp_o       (smp_o),
      .smp_valid_o (smp_valid_o),
      .smp_ready_i (smp_ready_i),
      .done_o      (done_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push_etu(input logic b, input string tag, input bit tag_form);
      for (int k = 0; k < (tag_form ? 4 : 1); k++) begin
         q_bit.push_back(b);
         q_tag.push_back(tag);
      end
   endtask

   // Downstream backpressure
   initial begin
      forever begin
         @(posedge clk);
         #1 smp_ready_i = bp_en ? (($urandom % 4) != 0) : 1'b1;
      end
   end

   // Monitor: pops expected samples, checks hold and done timing
   initial begin
      logic prev_v = 1'b0, prev_r = 1'b0, prev_s = 1'b0, prev_done = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_v && !prev_r)
               check(smp_valid_o && smp_o == prev_s, "R13", int'(smp_o), int'(prev_s));
            if (done_o) begin
               done_cnt++;
               check(prev_v && prev_r && q_bit.size() == 0, "R12", q_bit.size(), 0);
               check(!prev_done, "R12", int'(prev_done), 0);
            end
            if (smp_valid_o && smp_ready_i) begin
               if (q_bit.size() == 0) begin
                  check(1'b0, "R11", 1, 0);
               end else begin
                  logic  e;
                  string t;
                  e = q_bit.pop_front();
                  t = q_tag.pop_front();
                  check(smp_o == e, t, int'(smp_o), int'(e));
               end
            end
         end
         prev_v = smp_valid_o;
         prev_r = smp_ready_i;
         prev_s = smp_o;
         prev_done = done_o;
      end
   end

   task automatic feed_byte(input logic [7:0] d, input bit last, input int stall);
      if (stall > 0) begin
         do @(negedge clk); while (!in_ready_o);
         for (int k = 0; k < stall; k++) begin
            // R10: encoder waits without producing samples
            check(in_ready_o && !smp_valid_o, "R10", int'(smp_valid_o), 0);
            @(negedge clk);
         end
      end
      @(posedge clk);
      #1;
      in_data_i  = d;
      in_last_i  = last;
      in_valid_i = 1'b1;
      do @(negedge clk); while (!in_ready_o);
      @(posedge clk);
      #1 in_valid_i = 1'b0;
   endtask

   task automatic run_frame(input bit tag_form, input logic [7:0] bytes[8], input int n,
                            input int stall_at, input bit poke);
      int exp_done;
      exp_done = done_cnt + 1;
      if (tag_form)
         for (int k = 0; k < 20; k++) push_etu(1'b1, "R8", 1'b1);
      for (int k = 0; k < 10; k++) push_etu(1'b0, "R3", tag_form);
      for (int k = 0; k < 2; k++)  push_etu(1'b1, "R3", tag_form);
      for (int i = 0; i < n; i++) begin
         push_etu(1'b0, (i > 0) ? "R9" : "R2", tag_form);
         for (int k = 0; k < 8; k++) push_etu(bytes[i][k], tag_form ? "R7" : "R2", tag_form);
         push_etu(1'b1, "R2", tag_form);
      end
      for (int k = 0; k < 10; k++) push_etu(1'b0, tag_form ? "R4" : "R5", tag_form);
      for (int k = 0; k < (tag_form ? 2 : 1); k++) push_etu(1'b1, tag_form ? "R4" : "R5", tag_form);
      if (!tag_form)
         for (int k = 0; k < 8; k++) push_etu(1'b1, "R6", 1'b0);

      @(posedge clk);
      #1;
      start_i    = 1'b1;
      tag_mode_i = tag_form;
      @(posedge clk);
      #1 start_i = 1'b0;

      fork
         begin
            for (int i = 0; i < n; i++)
               feed_byte(bytes[i], i == n - 1, (i == stall_at) ? 6 : 0);
         end
         begin
            if (poke) begin
               // R11: second start with opposite mode while busy
               repeat (25) @(posedge clk);
               #1;
               start_i    = 1'b1;
               tag_mode_i = !tag_form;
               @(posedge clk);
               #1 start_i = 1'b0;
            end
         end
      join
      wait (done_cnt == exp_done);
      repeat (3) @(negedge clk);
      check(q_bit.size() == 0 && done_cnt == exp_done, "R11", done_cnt, exp_done);
      check(!smp_valid_o && !in_ready_o, "R12", int'(smp_valid_o), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] b[8];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!smp_valid_o && !in_ready_o && !done_o, "R1", int'(smp_valid_o), 0);
      #1 rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!smp_valid_o && !in_ready_o && !done_o, "R1", int'(in_ready_o), 0);

      b = '{8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      run_frame(1'b0, b, 1, -1, 1'b0);

      bp_en = 1'b1;
      b = '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      run_frame(1'b0, b, 3, 1, 1'b1);

      b = '{8'h5A, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      run_frame(1'b1, b, 2, -1, 1'b0);

      b = '{8'h00, 8'hC3, 8'h7E, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00};
      run_frame(1'b1, b, 4, 2, 1'b1);

      bp_en = 1'b0;
      b = '{8'hFF, 8'h00, 8'h96, 8'h69, 8'h11, 8'h00, 8'h00, 8'h00};
      run_frame(1'b0, b, 5, 3, 1'b1);

      fin = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule